// File: doc/BRIEF.md
# Infrared Mode Control and Interaction Pulse Timer

This block is a control slice for a serial port that can run several infrared line modes. It holds the 3-bit operating mode written by the CPU. Whenever a write actually changes that mode, the block issues one-cycle soft-reset strobes to the transmitter and the receiver, and a strobe that clears the modem status events. A write that repeats the current mode issues none of them.

The block also keeps a sticky request bit for an infrared interaction pulse. Software arms it by writing a one. When the transmitter signals the end of a frame in one of the two high-speed modes, the block drives a pulse of fixed duration on its infrared output and clears the request. The duration is converted from nanoseconds to clock cycles using a clock-frequency parameter. A transmitter soft reset, whether it comes from outside or from a mode change, drops the request and cuts short any pulse in flight.

Top module: `irmode_ctl`

## Requirements
- R1: Synchronous reset sets `mode` to 000 (UART) and drives `pulse_req`, `ir_pulse`, `tx_soft_rst`, `rx_soft_rst` and `evt_clr` low, with no mode-change strobe issued.
- R2: A write (`wr_en`=1) whose `wr_mode` differs from `mode` loads `mode` at that edge. `tx_soft_rst`, `rx_soft_rst` and `evt_clr` are then high together for exactly the one following cycle.
- R3: A write whose `wr_mode` equals the current `mode` raises none of the three strobes.
- R4: A write with `wr_pulse_set`=1 sets `pulse_req` from the next cycle. A write with `wr_pulse_set`=0 leaves it unchanged.
- R5: An `eof_strobe` while `pulse_req`=1, `mode` is 100 (MIR) or 101 (FIR) and no pulse is running makes `ir_pulse` high for exactly PULSE_CYC = CLK_HZ*PULSE_NS/1e9 consecutive cycles, starting the next cycle (500 cycles at 250 MHz and 2000 ns). `pulse_req` clears at that same edge.
- R6: In any mode other than 100 or 101, `eof_strobe` raises no pulse and `pulse_req` stays set. With `pulse_req`=0, no pulse starts in any mode.
- R7: An `eof_strobe` that arrives while a pulse is running is ignored. The pulse keeps its length, and a `pulse_req` that was re-armed meanwhile stays set.
- R8: `tx_rst_req`=1 clears `pulse_req` and ends a running pulse at the next edge.
- R9: A mode-changing write clears `pulse_req` and ends a running pulse, even if the same write sets `wr_pulse_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe for the control register |
| wr_mode | input | 3 | Mode value written |
| wr_pulse_set | input | 1 | Write-one-to-set for the pulse request |
| eof_strobe | input | 1 | End of transmitted frame, one cycle |
| tx_rst_req | input | 1 | External transmitter soft-reset request |
| mode | output | 3 | Current operating mode |
| pulse_req | output | 1 | Pending interaction pulse request |
| tx_soft_rst | output | 1 | Transmitter soft-reset strobe |
| rx_soft_rst | output | 1 | Receiver soft-reset strobe |
| evt_clr | output | 1 | Modem status event clear strobe |
| ir_pulse | output | 1 | Infrared interaction pulse output |

## Verification
The following are checked on every cycle: the three strobes follow any mode-changing write and only such a write, a pulse can begin only from a high-speed mode and always consumes the request, a transmitter reset leaves both request and pulse low, and a pulse that is not cut short lasts exactly PULSE_CYC cycles. Only the bench scenarios can show the following: the value of the request bit across sequences of writes, the request surviving end-of-frame strobes in slow modes or during a running pulse, and the exact 500-cycle width seen at the output at 250 MHz.

// File: rtl/irmode_pkg.sv
package irmode_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_UART  = 3'b000,
    MD_RSV_A = 3'b001,
    MD_ASKIR = 3'b010,
    MD_SIR   = 3'b011,
    MD_MIR   = 3'b100,
    MD_FIR   = 3'b101,
    MD_CIR   = 3'b110,
    MD_RSV_B = 3'b111
  } ir_mode_e;

  function automatic logic is_fast(input logic [MODE_W-1:0] m);
    return (m == MD_MIR) || (m == MD_FIR);
  endfunction
endpackage

// File: rtl/irmode_mode_reg.sv
module irmode_mode_reg
  import irmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  output logic [MODE_W-1:0] mode,
  output logic              mode_chg,
  output logic              tx_soft_rst,
  output logic              rx_soft_rst,
  output logic              evt_clr
);
  assign mode_chg = wr_en && (wr_mode != mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode        <= MD_UART;
      tx_soft_rst <= 1'b0;
      rx_soft_rst <= 1'b0;
      evt_clr     <= 1'b0;
    end else begin
      if (mode_chg) mode <= wr_mode;
      tx_soft_rst <= mode_chg;
      rx_soft_rst <= mode_chg;
      evt_clr     <= mode_chg;
    end
  end
endmodule

// File: rtl/irmode_req_bit.sv
module irmode_req_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  input  logic consume,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst)                     req <= 1'b0;
    else if (clr_req || consume) req <= 1'b0;
    else if (set_req)            req <= 1'b1;
  end
endmodule

// File: rtl/irmode_pulse_timer.sv
module irmode_pulse_timer #(
  parameter int PULSE_CYC = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic pulse
);
  localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      pulse  <= 1'b0;
      remain <= '0;
    end else if (pulse) begin
      if (remain == '0) pulse <= 1'b0;
      else              remain <= remain - 1'b1;
    end else if (start) begin
      pulse  <= 1'b1;
      remain <= LAST;
    end
  end
endmodule

// File: rtl/irmode_ctl.sv
module irmode_ctl
  import irmode_pkg::*;
#(
  parameter longint CLK_HZ   = 250_000_000,
  parameter longint PULSE_NS = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              wr_pulse_set,
  input  logic              eof_strobe,
  input  logic              tx_rst_req,
  output logic [MODE_W-1:0] mode,
  output logic              pulse_req,
  output logic              tx_soft_rst,
  output logic              rx_soft_rst,
  output logic              evt_clr,
  output logic              ir_pulse
);
  localparam longint RAW_CYC   = (CLK_HZ * PULSE_NS) / 64'd1_000_000_000;
  localparam int     PULSE_CYC = (RAW_CYC < 1) ? 1 : int'(RAW_CYC);

  logic mode_chg;
  logic tx_clear;
  logic start;

  irmode_mode_reg u_mode (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_mode     (wr_mode),
    .mode        (mode),
    .mode_chg    (mode_chg),
    .tx_soft_rst (tx_soft_rst),
    .rx_soft_rst (rx_soft_rst),
    .evt_clr     (evt_clr)
  );

  // a transmitter reset from either source cancels request and pulse
  assign tx_clear = tx_rst_req || mode_chg;
  assign start    = eof_strobe && pulse_req && is_fast(mode) && !ir_pulse && !tx_clear;

  irmode_req_bit u_req (
    .clk     (clk),
    .rst     (rst),
    .set_req (wr_en && wr_pulse_set),
    .clr_req (tx_clear),
    .consume (start),
    .req     (pulse_req)
  );

  irmode_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .abort (tx_clear),
    .pulse (ir_pulse)
  );
endmodule

// File: rtl/irmode_ctl_chk.sv
module irmode_ctl_chk #(
  parameter int PULSE_CYC = 500
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [2:0] wr_mode,
  input logic       tx_rst_req,
  input logic [2:0] mode,
  input logic       pulse_req,
  input logic       tx_soft_rst,
  input logic       rx_soft_rst,
  input logic       evt_clr,
  input logic       ir_pulse
);
  logic        chg_w;
  logic        abort_w;
  logic [31:0] hi_cnt;

  assign chg_w   = wr_en && (wr_mode != mode);
  assign abort_w = chg_w || tx_rst_req;

  always_ff @(posedge clk) begin
    if (rst || !ir_pulse) hi_cnt <= '0;
    else                  hi_cnt <= hi_cnt + 1;
  end

  // R2
  strobe_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    chg_w |=> (tx_soft_rst && rx_soft_rst && evt_clr && mode == $past(wr_mode)));

  // R3
  no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !chg_w |=> (!tx_soft_rst && !rx_soft_rst && !evt_clr));

  // R6
  fast_mode_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_pulse) |-> ($past(mode) == 3'b100 || $past(mode) == 3'b101));

  // R5
  start_consumes_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_pulse) |-> (!pulse_req && $past(pulse_req)));

  // R8
  txrst_clears_chk: assert property (@(posedge clk) disable iff (rst)
    tx_rst_req |=> (!pulse_req && !ir_pulse));

  // R9
  change_clears_chk: assert property (@(posedge clk) disable iff (rst)
    chg_w |=> (!pulse_req && !ir_pulse));

  // R5
  width_cap_chk: assert property (@(posedge clk) disable iff (rst)
    ir_pulse |-> (hi_cnt < 32'(PULSE_CYC)));

  // R7
  width_full_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ir_pulse) && !$past(abort_w)) |-> ($past(hi_cnt) == 32'(PULSE_CYC - 1)));
endmodule

bind irmode_ctl irmode_ctl_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_mode     (wr_mode),
  .tx_rst_req  (tx_rst_req),
  .mode        (mode),
  .pulse_req   (pulse_req),
  .tx_soft_rst (tx_soft_rst),
  .rx_soft_rst (rx_soft_rst),
  .evt_clr     (evt_clr),
  .ir_pulse    (ir_pulse)
);

// File: tb/irmode_ctl_test.sv
`timescale 1ns/1ps
module irmode_ctl_test;
  localparam int EXP_W = 500;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_mode = 3'b000;
  logic       wr_pulse_set = 1'b0;
  logic       eof_strobe = 1'b0;
  logic       tx_rst_req = 1'b0;
  logic [2:0] mode;
  logic       pulse_req, tx_soft_rst, rx_soft_rst, evt_clr, ir_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irmode_ctl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode),
    .wr_pulse_set(wr_pulse_set), .eof_strobe(eof_strobe), .tx_rst_req(tx_rst_req),
    .mode(mode), .pulse_req(pulse_req), .tx_soft_rst(tx_soft_rst),
    .rx_soft_rst(rx_soft_rst), .evt_clr(evt_clr), .ir_pulse(ir_pulse)
  );

  // {wr_mode, wr_pulse_set, expected strobe, expected pulse_req}
  localparam logic [5:0] VEC [8] = '{
    {3'b011, 1'b0, 1'b1, 1'b0},
    {3'b011, 1'b1, 1'b0, 1'b1},
    {3'b011, 1'b0, 1'b0, 1'b1},
    {3'b100, 1'b0, 1'b1, 1'b0},
    {3'b100, 1'b1, 1'b0, 1'b1},
    {3'b101, 1'b1, 1'b1, 1'b0},
    {3'b101, 1'b1, 1'b0, 1'b1},
    {3'b000, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write(input logic [2:0] m, input logic s);
    @(negedge clk);
    wr_en = 1'b1; wr_mode = m; wr_pulse_set = s;
    @(negedge clk);
    wr_en = 1'b0; wr_pulse_set = 1'b0;
  endtask

  task automatic pulse_eof();
    @(negedge clk); eof_strobe = 1'b1;
    @(negedge clk); eof_strobe = 1'b0;
  endtask

  task automatic strobes_are(input bit v, input string tag);
    check(tx_soft_rst == v && rx_soft_rst == v && evt_clr == v, tag,
          {tx_soft_rst, rx_soft_rst, evt_clr}, v ? 7 : 0);
  endtask

  initial begin
    #(4 * 150_000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mode == 3'b000, "R1 mode", mode, 0);
    check(!pulse_req && !ir_pulse, "R1 req/pulse", {pulse_req, ir_pulse}, 0);
    strobes_are(1'b0, "R1 strobes");
    rst = 1'b0;

    // R2 R3 R4 R9 vector walk
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_mode = VEC[i][5:3]; wr_pulse_set = VEC[i][2];
      @(negedge clk);
      wr_en = 1'b0; wr_pulse_set = 1'b0;
      check(mode == VEC[i][5:3], "R2 mode load", mode, VEC[i][5:3]);
      strobes_are(VEC[i][1], VEC[i][1] ? "R2 strobe" : "R3 no strobe");
      check(pulse_req == VEC[i][0], "R4/R9 req", pulse_req, VEC[i][0]);
    end

    // R2 strobe lasts one cycle
    @(negedge clk); wr_en = 1'b1; wr_mode = 3'b100;
    @(negedge clk); wr_en = 1'b0;
    strobes_are(1'b1, "R2 strobe high");
    @(negedge clk);
    strobes_are(1'b0, "R2 strobe single cycle");

    // R5 R7 MIR pulse width, eof during pulse ignored
    write(3'b100, 1'b1);
    check(pulse_req, "R4 set", pulse_req, 1);
    cnt = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (ir_pulse) cnt++;
      if (i == 1) check(ir_pulse && !pulse_req, "R5 start/consume", {ir_pulse, pulse_req}, 2);
      eof_strobe   = (i == 0) || (i == 200);
      wr_en        = (i == 100);
      wr_mode      = 3'b100;
      wr_pulse_set = (i == 100);
    end
    check(cnt == EXP_W, "R5/R7 width", cnt, EXP_W);
    check(pulse_req, "R7 req kept", pulse_req, 1);

    // R6 slow mode: no pulse, request kept
    write(3'b011, 1'b0);
    write(3'b011, 1'b1);
    pulse_eof();
    cnt = 0;
    repeat (5) begin @(negedge clk); if (ir_pulse) cnt++; end
    check(cnt == 0, "R6 no pulse SIR", cnt, 0);
    check(pulse_req, "R6 req kept", pulse_req, 1);

    // R6 no request: no pulse in FIR
    write(3'b101, 1'b0);
    check(!pulse_req, "R9 change clears", pulse_req, 0);
    pulse_eof();
    check(!ir_pulse, "R6 no req no pulse", ir_pulse, 0);

    // R8 abort FIR pulse by tx_rst_req
    write(3'b101, 1'b1);
    pulse_eof();
    check(ir_pulse, "R5 FIR start", ir_pulse, 1);
    repeat (10) @(negedge clk);
    write(3'b101, 1'b1);
    tx_rst_req = 1'b1;
    @(negedge clk); tx_rst_req = 1'b0;
    check(!ir_pulse && !pulse_req, "R8 abort", {ir_pulse, pulse_req}, 0);

    // R9 mode change ends running pulse
    write(3'b101, 1'b1);
    pulse_eof();
    repeat (5) @(negedge clk);
    write(3'b100, 1'b1);
    check(!ir_pulse && !pulse_req, "R9 change abort", {ir_pulse, pulse_req}, 0);

    // R1 reset mid-operation
    write(3'b100, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(mode == 3'b000 && !pulse_req, "R1 reset", {mode, pulse_req}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    strobes_are(1'b0, "R1 no strobe after reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule